// File: doc/BRIEF.md
# Macroblock Deblocking Neighbour Edge Buffer

This block sits between a macroblock reconstruction stage and a deblocking filter engine for 16x16 luma macroblocks of 8-bit pixels. Reconstructed macroblocks arrive in raster order, one 16-pixel row per beat. For each macroblock the block builds a filter window from the current block, the four rightmost columns of the macroblock to its left, and the four bottom rows of the macroblock above. It streams that window to the filter, takes the filtered result back, and forwards the filtered pixels to the frame store on a write-back port.

No neighbour pixels are ever fetched back from the frame store. The left edge lives in a slot of the window buffer next to the current block. Each filter result overwrites that slot with its own rightmost four columns, which are then ready as the next macroblock's left edge. The unfiltered bottom four rows of every macroblock go into a line buffer that spans one macroblock row. They are read back as the top edge of the macroblock directly below.

All three streaming ports use a valid/ready handshake. Back-pressure on any of them holds the macroblock position counters. The frame size is given in macroblocks on two static inputs.

Top module: `nbr_edge_buf`

## Requirements
- R1: After reset the block is ready for input (inReady=1), has no window or write-back beat pending, and the first macroblock it takes is at column 0, row 0.
- R2: A macroblock is 16 accepted input beats. Pixel k of a row (k=0 leftmost) is inRow[8k+7:8k]. After the 16th beat is accepted, inReady stays low until every filter result beat of that macroblock has been written back.
- R3: A window beat carries a beat number on winBeat. Beats 0..3 are top-edge rows. Beats 4..19 are body rows, where row r = beat-4. In a body beat, pixel p of winData sits at bits [8p+7:8p]: pixels 4..19 are current row r exactly as it was input, and pixels 0..3 are the left edge.
- R4: For a macroblock in column > 0, body beat r carries in pixels 0..3 the pixels 16..19 of filter result body beat r of the previous macroblock.
- R5: For a macroblock in column 0, winLeftAvail is 0 and pixels 0..3 of every window beat are zero.
- R6: For a macroblock in row > 0, winTopAvail is 1 and the window starts with beats 0..3. Top beat k carries, in pixels 4..19, input row 12+k of the macroblock at the same column one row above, and zeros in pixels 0..3.
- R7: For a macroblock in row 0, winTopAvail is 0, the window starts at beat 4, and the filter result is expected to start at beat 4 too.
- R8: Each filter result beat (same layout and order as the window) is passed to the write-back port unchanged, tagged with its beat number and macroblock position. No other beat appears there.
- R9: While winValid is high and winReady low, winValid stays high and winData and winBeat hold. While wbReady is low, no filter result beat is accepted.
- R10: Macroblock positions advance in raster order within frameWMbs x frameHMbs. After the last macroblock of a frame the position wraps to (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameWMbs | input | XW+1 | Frame width in macroblocks (1..MAX_W_MBS) |
| frameHMbs | input | YW+1 | Frame height in macroblocks (1..MAX_H_MBS) |
| inValid | input | 1 | Input row valid |
| inReady | output | 1 | Input row accepted |
| inRow | input | 128 | One reconstructed row of 16 pixels |
| winValid | output | 1 | Filter window beat valid |
| winReady | input | 1 | Filter takes window beat |
| winData | output | 160 | Window beat, 20 pixels |
| winBeat | output | 5 | Window beat number 0..19 |
| winTopAvail | output | 1 | Top edge present for this macroblock |
| winLeftAvail | output | 1 | Left edge present for this macroblock |
| winMbX | output | XW | Macroblock column of the window |
| winMbY | output | YW | Macroblock row of the window |
| fltValid | input | 1 | Filter result beat valid |
| fltReady | output | 1 | Filter result beat accepted |
| fltData | input | 160 | Filter result beat, window layout |
| wbValid | output | 1 | Write-back beat valid |
| wbReady | input | 1 | Frame store takes write-back beat |
| wbData | output | 160 | Filtered pixels for the frame store |
| wbBeat | output | 5 | Beat number of the write-back beat |
| wbMbX | output | XW | Macroblock column of the write-back beat |
| wbMbY | output | YW | Macroblock row of the write-back beat |

## Verification
The bench runs two 3x3 frames with random stalls on window and write-back ready. This covers the top-row and left-column cases and the wrap from the last macroblock back to (0,0). If the line-buffer slot were written before it is read, the top edge below would carry the current block's rows instead of those of the block above. If the left slot were not cleared at column 0, the left bits would carry the previous row's last macroblock. If the edge slot took the wrong four columns of the filter result, every body beat for column 1 and up would show that. A design that ignores winReady would skip window beats, and one that lets the filter run ahead of the write-back would lose beats. Both show up as missing or out-of-order scoreboard items.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int PIX    = 8;
  localparam int MB     = 16;
  localparam int EDGE   = 4;
  localparam int ROW_W  = MB * PIX;
  localparam int EDGE_W = EDGE * PIX;
  localparam int WIN_W  = ROW_W + EDGE_W;
  localparam int BEATS  = EDGE + MB;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int ROWIX_W = $clog2(MB);
  localparam int EDGEIX_W = $clog2(EDGE);

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } phase_t;

  typedef struct packed {
    logic              rowWe;
    logic              sendFire;
    logic              recvFire;
    logic [BEAT_W-1:0] beat;
    logic              topAvail;
    logic              leftAvail;
    logic              keepBottom;
  } strobe_t;
endpackage

// File: rtl/nbr_ctrl.sv
module nbr_ctrl
  import nbr_pkg::*;
#(
  parameter int MAX_W_MBS = 8,
  parameter int MAX_H_MBS = 8,
  localparam int XW = (MAX_W_MBS > 1) ? $clog2(MAX_W_MBS) : 1,
  localparam int YW = (MAX_H_MBS > 1) ? $clog2(MAX_H_MBS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [XW:0]   frameWMbs,
  input  logic [YW:0]   frameHMbs,
  input  logic          inValid,
  output logic          inReady,
  output logic          winValid,
  input  logic          winReady,
  input  logic          fltValid,
  output logic          fltReady,
  output logic          wbValid,
  input  logic          wbReady,
  output logic [XW-1:0] mbX,
  output logic [YW-1:0] mbY,
  output strobe_t       stb
);
  phase_t            phase;
  logic [BEAT_W-1:0] beat;
  logic              topAvail, leftAvail;
  logic [BEAT_W-1:0] firstBeat;
  logic              inFire, sendFire, recvFire;
  logic              lastBeat, lastRow, lastCol, lastMbRow;

  assign topAvail  = (mbY != '0);
  assign leftAvail = (mbX != '0);
  assign firstBeat = topAvail ? '0 : BEAT_W'(EDGE);
  assign lastBeat  = (beat == BEAT_W'(BEATS - 1));
  assign lastRow   = (beat == BEAT_W'(MB - 1));
  assign lastCol   = ({1'b0, mbX} == frameWMbs - (XW + 1)'(1));
  assign lastMbRow = ({1'b0, mbY} == frameHMbs - (YW + 1)'(1));

  // Phase-gated handshakes; the write-back port is a straight pass of the filter result
  assign inReady  = (phase == ST_LOAD);
  assign winValid = (phase == ST_SEND);
  assign fltReady = (phase == ST_RECV) && wbReady;
  assign wbValid  = (phase == ST_RECV) && fltValid;

  assign inFire   = inValid && inReady;
  assign sendFire = winValid && winReady;
  assign recvFire = fltValid && fltReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= ST_LOAD;
      beat  <= '0;
      mbX   <= '0;
      mbY   <= '0;
    end else begin
      unique case (phase)
        ST_LOAD: if (inFire) begin
          if (lastRow) begin
            phase <= ST_SEND;
            beat  <= firstBeat;
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        ST_SEND: if (sendFire) begin
          if (lastBeat) begin
            phase <= ST_RECV;
            beat  <= firstBeat;
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        ST_RECV: if (recvFire) begin
          if (lastBeat) begin
            phase <= ST_LOAD;
            beat  <= '0;
            if (lastCol) begin
              mbX <= '0;
              mbY <= lastMbRow ? '0 : mbY + YW'(1);
            end else begin
              mbX <= mbX + XW'(1);
            end
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        default: phase <= ST_LOAD;
      endcase
    end
  end

  always_comb begin
    stb.rowWe      = inFire;
    stb.sendFire   = sendFire;
    stb.recvFire   = recvFire;
    stb.beat       = beat;
    stb.topAvail   = topAvail;
    stb.leftAvail  = leftAvail;
    stb.keepBottom = !lastMbRow;
  end
endmodule

// File: rtl/nbr_dpath.sv
module nbr_dpath
  import nbr_pkg::*;
#(
  parameter int MAX_W_MBS = 8,
  localparam int XW = (MAX_W_MBS > 1) ? $clog2(MAX_W_MBS) : 1,
  localparam int LB_AW = XW + EDGEIX_W,
  localparam int LB_DEPTH = 1 << LB_AW
) (
  input  logic             clk,
  input  strobe_t          stb,
  input  logic [XW-1:0]    mbX,
  input  logic [ROW_W-1:0] inRow,
  input  logic [WIN_W-1:0] fltData,
  output logic [WIN_W-1:0] winData
);
  logic [ROW_W-1:0]   curRows  [MB];
  logic [EDGE_W-1:0]  leftRows [MB];
  logic [ROW_W-1:0]   lineBuf  [LB_DEPTH];

  logic [BEAT_W-1:0]  bodyBeat;
  logic [ROWIX_W-1:0] bodyIdx;
  logic [ROWIX_W-1:0] loadIdx;
  logic               isTop, isBottom;
  logic [LB_AW-1:0]   lbAddr;

  assign bodyBeat = stb.beat - BEAT_W'(EDGE);
  assign bodyIdx  = bodyBeat[ROWIX_W-1:0];
  assign loadIdx  = stb.beat[ROWIX_W-1:0];
  assign isTop    = (stb.beat < BEAT_W'(EDGE));
  assign isBottom = (stb.beat >= BEAT_W'(BEATS - EDGE));
  // top beats 0..3 and bottom beats 16..19 share the low bits as edge-row index
  assign lbAddr   = {mbX, stb.beat[EDGEIX_W-1:0]};

  // window buffer: one current row and its left-edge slot per body row
  for (genvar r = 0; r < MB; r++) begin : g_row
    logic [ROW_W-1:0]  curQ;
    logic [EDGE_W-1:0] leftQ;
    always_ff @(posedge clk) begin
      if (stb.rowWe && loadIdx == ROWIX_W'(r))
        curQ <= inRow;
      // rightmost filtered columns land in the slot the next block reads as its left edge
      if (stb.recvFire && !isTop && bodyIdx == ROWIX_W'(r))
        leftQ <= fltData[WIN_W-1 -: EDGE_W];
    end
    assign curRows[r]  = curQ;
    assign leftRows[r] = leftQ;
  end

  // unfiltered bottom rows saved while they are sent, after this column's top was read
  always_ff @(posedge clk) begin
    if (stb.sendFire && isBottom && stb.keepBottom)
      lineBuf[lbAddr] <= curRows[bodyIdx];
  end

  always_comb begin
    if (isTop)
      winData = {lineBuf[lbAddr], EDGE_W'(0)};
    else
      winData = {curRows[bodyIdx], stb.leftAvail ? leftRows[bodyIdx] : EDGE_W'(0)};
  end
endmodule

// File: rtl/nbr_edge_buf.sv
module nbr_edge_buf
  import nbr_pkg::*;
#(
  parameter int MAX_W_MBS = 8,
  parameter int MAX_H_MBS = 8,
  localparam int XW = (MAX_W_MBS > 1) ? $clog2(MAX_W_MBS) : 1,
  localparam int YW = (MAX_H_MBS > 1) ? $clog2(MAX_H_MBS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [XW:0]       frameWMbs,
  input  logic [YW:0]       frameHMbs,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ROW_W-1:0]  inRow,
  output logic              winValid,
  input  logic              winReady,
  output logic [WIN_W-1:0]  winData,
  output logic [BEAT_W-1:0] winBeat,
  output logic              winTopAvail,
  output logic              winLeftAvail,
  output logic [XW-1:0]     winMbX,
  output logic [YW-1:0]     winMbY,
  input  logic              fltValid,
  output logic              fltReady,
  input  logic [WIN_W-1:0]  fltData,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [WIN_W-1:0]  wbData,
  output logic [BEAT_W-1:0] wbBeat,
  output logic [XW-1:0]     wbMbX,
  output logic [YW-1:0]     wbMbY
);
  strobe_t       stb;
  logic [XW-1:0] mbX;
  logic [YW-1:0] mbY;

  nbr_ctrl #(.MAX_W_MBS(MAX_W_MBS), .MAX_H_MBS(MAX_H_MBS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameWMbs(frameWMbs), .frameHMbs(frameHMbs),
    .inValid(inValid), .inReady(inReady),
    .winValid(winValid), .winReady(winReady),
    .fltValid(fltValid), .fltReady(fltReady),
    .wbValid(wbValid), .wbReady(wbReady),
    .mbX(mbX), .mbY(mbY), .stb(stb)
  );

  nbr_dpath #(.MAX_W_MBS(MAX_W_MBS)) u_dpath (
    .clk(clk), .stb(stb), .mbX(mbX),
    .inRow(inRow), .fltData(fltData), .winData(winData)
  );

  assign winBeat      = stb.beat;
  assign winTopAvail  = stb.topAvail;
  assign winLeftAvail = stb.leftAvail;
  assign winMbX       = mbX;
  assign winMbY       = mbY;
  assign wbData       = fltData;
  assign wbBeat       = stb.beat;
  assign wbMbX        = mbX;
  assign wbMbY        = mbY;
endmodule

// File: rtl/nbr_edge_buf_chk.sv
module nbr_edge_buf_chk
  import nbr_pkg::*;
#(
  parameter int MAX_W_MBS = 8,
  parameter int MAX_H_MBS = 8,
  localparam int XW = (MAX_W_MBS > 1) ? $clog2(MAX_W_MBS) : 1,
  localparam int YW = (MAX_H_MBS > 1) ? $clog2(MAX_H_MBS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [XW:0]       frameWMbs,
  input logic [YW:0]       frameHMbs,
  input logic              inReady,
  input logic              winValid,
  input logic              winReady,
  input logic [WIN_W-1:0]  winData,
  input logic [BEAT_W-1:0] winBeat,
  input logic              winTopAvail,
  input logic              winLeftAvail,
  input logic [XW-1:0]     winMbX,
  input logic [YW-1:0]     winMbY,
  input logic              fltValid,
  input logic              fltReady,
  input logic              wbValid,
  input logic              wbReady
);
  // R9
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !winReady) |=> (winValid && $stable(winData) && $stable(winBeat)));

  // R5
  left_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winMbX == '0) |-> (!winLeftAvail && winData[EDGE_W-1:0] == '0));

  // R7
  top_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && winMbY == '0) |-> (!winTopAvail && winBeat >= BEAT_W'(EDGE)));

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && (winValid || fltReady)));

  // R8
  wb_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fltValid && fltReady) |-> (wbValid && wbReady));

  // R10
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> ({1'b0, winMbX} < frameWMbs && {1'b0, winMbY} < frameHMbs));
endmodule

bind nbr_edge_buf nbr_edge_buf_chk #(.MAX_W_MBS(MAX_W_MBS), .MAX_H_MBS(MAX_H_MBS)) u_chk (.*);

// File: tb/nbr_edge_buf_tb.sv
module nbr_edge_buf_tb;
  typedef struct packed {
    logic [159:0] d;
    logic [4:0]   b;
    logic [2:0]   x;
    logic [2:0]   y;
    logic         t;
    logic         l;
  } win_item_t;

  typedef struct packed {
    logic [159:0] d;
    logic [4:0]   b;
    logic [2:0]   x;
    logic [2:0]   y;
  } wb_item_t;

  localparam int FW = 3;
  localparam int FH = 3;
  localparam int FRAMES = 2;

  logic clk = 0;
  logic rstN = 0;
  logic [3:0] frameWMbs = 4'(FW);
  logic [3:0] frameHMbs = 4'(FH);
  logic inValid = 0;
  logic inReady;
  logic [127:0] inRow = '0;
  logic winValid;
  logic winReady = 0;
  logic [159:0] winData;
  logic [4:0] winBeat;
  logic winTopAvail, winLeftAvail;
  logic [2:0] winMbX, winMbY;
  logic fltValid = 0;
  logic fltReady;
  logic [159:0] fltData = '0;
  logic wbValid;
  logic wbReady = 0;
  logic [159:0] wbData;
  logic [4:0] wbBeat;
  logic [2:0] wbMbX, wbMbY;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  win_item_t    winQ[$];
  wb_item_t     wbQ[$];
  logic [159:0] fltQ[$];

  logic [31:0]  mLeft [16];
  logic [127:0] mLine [8][4];

  always #10 clk = ~clk;

  nbr_edge_buf u_dut (
    .clk(clk), .rstN(rstN), .frameWMbs(frameWMbs), .frameHMbs(frameHMbs),
    .inValid(inValid), .inReady(inReady), .inRow(inRow),
    .winValid(winValid), .winReady(winReady), .winData(winData), .winBeat(winBeat),
    .winTopAvail(winTopAvail), .winLeftAvail(winLeftAvail), .winMbX(winMbX), .winMbY(winMbY),
    .fltValid(fltValid), .fltReady(fltReady), .fltData(fltData),
    .wbValid(wbValid), .wbReady(wbReady), .wbData(wbData), .wbBeat(wbBeat),
    .wbMbX(wbMbX), .wbMbY(wbMbY)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] rowVal(int f, int x, int y, int r);
    logic [127:0] v;
    for (int k = 0; k < 16; k++)
      v[8*k +: 8] = 8'(f*73 + x*37 + y*101 + r*13 + k*7 + r*k + 5);
    return v;
  endfunction

  function automatic logic [159:0] fmask(int b, int x, int y);
    logic [159:0] v;
    for (int k = 0; k < 20; k++)
      v[8*k +: 8] = 8'(b*29 + k*3 + x*11 + y*17 + 90);
    return v;
  endfunction

  // driver: pushes expectations for one macroblock, then feeds its rows
  task automatic driveMb(int f, int x, int y);
    logic [31:0]  newLeft [16];
    logic [127:0] newLine [4];
    win_item_t wi;
    wb_item_t  bi;
    logic [159:0] w, fr;
    bit topA, leftA;
    topA  = (y != 0);
    leftA = (x != 0);
    if (topA) begin
      for (int k = 0; k < 4; k++) begin
        w = {mLine[x][k], 32'h0};
        wi = '{d: w, b: 5'(k), x: 3'(x), y: 3'(y), t: topA, l: leftA};
        winQ.push_back(wi);
        fr = w ^ fmask(k, x, y);
        fltQ.push_back(fr);
        bi = '{d: fr, b: 5'(k), x: 3'(x), y: 3'(y)};
        wbQ.push_back(bi);
      end
    end
    for (int r = 0; r < 16; r++) begin
      w = {rowVal(f, x, y, r), leftA ? mLeft[r] : 32'h0};
      wi = '{d: w, b: 5'(r + 4), x: 3'(x), y: 3'(y), t: topA, l: leftA};
      winQ.push_back(wi);
      fr = w ^ fmask(r + 4, x, y);
      fltQ.push_back(fr);
      bi = '{d: fr, b: 5'(r + 4), x: 3'(x), y: 3'(y)};
      wbQ.push_back(bi);
      newLeft[r] = fr[159:128];
      if (r >= 12) newLine[r-12] = rowVal(f, x, y, r);
    end
    for (int r = 0; r < 16; r++) mLeft[r] = newLeft[r];
    for (int k = 0; k < 4; k++) mLine[x][k] = newLine[k];
    for (int r = 0; r < 16; r++) begin
      inValid = 1;
      inRow   = rowVal(f, x, y, r);
      forever begin
        @(negedge clk);
        if (inReady) break;
      end
      @(posedge clk); #1;
      inValid = 0;
    end
    @(negedge clk);
    check(inReady == 0, "R2", "inReady after 16 rows", 160'(inReady), 160'(0));
  endtask

  // ready randomiser for window and write-back ports
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      winReady = lfsr[0] | lfsr[3];
      wbReady  = lfsr[1] | lfsr[5];
    end
  end

  // filter model: returns precomputed results with occasional idle cycles
  initial begin
    int gap = 0;
    forever begin
      @(posedge clk); #1;
      if (fltQ.size() > 0) begin
        gap++;
        if (gap % 3 != 0) begin
          fltValid = 1;
          fltData  = fltQ.pop_front();
          forever begin
            @(negedge clk);
            if (fltReady) break;
          end
          @(posedge clk); #1;
          fltValid = 0;
        end
      end
    end
  end

  // monitors: compare window and write-back beats against the scoreboard
  logic         prevStall = 0;
  logic [159:0] prevData;
  logic [4:0]   prevBeat;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check(winValid && winData == prevData && winBeat == prevBeat, "R9",
              "window held under stall", winData, prevData);
      end
      prevStall = winValid && !winReady;
      prevData  = winData;
      prevBeat  = winBeat;
      if (winValid && winReady) begin
        if (winQ.size() == 0) begin
          check(0, "R3", "unexpected window beat", winData, '0);
        end else begin
          win_item_t e;
          e = winQ.pop_front();
          check(winBeat == e.b, e.t ? "R3" : "R7", "window beat number", 160'(winBeat), 160'(e.b));
          check(winMbX == e.x && winMbY == e.y, "R10", "window position",
                160'({winMbX, winMbY}), 160'({e.x, e.y}));
          check(winTopAvail == e.t, e.t ? "R6" : "R7", "top available", 160'(winTopAvail), 160'(e.t));
          check(winLeftAvail == e.l, e.l ? "R4" : "R5", "left available", 160'(winLeftAvail), 160'(e.l));
          if (e.b < 4) begin
            check(winData == e.d, "R6", "top edge beat", winData, e.d);
          end else begin
            check(winData[159:32] == e.d[159:32], "R3", "current row", winData, e.d);
            check(winData[31:0] == e.d[31:0], e.l ? "R4" : "R5", "left edge", winData, e.d);
          end
        end
      end
      if (wbValid && wbReady) begin
        if (wbQ.size() == 0) begin
          check(0, "R8", "unexpected write-back beat", wbData, '0);
        end else begin
          wb_item_t e;
          e = wbQ.pop_front();
          check(wbData == e.d, "R8", "write-back data", wbData, e.d);
          check(wbBeat == e.b && wbMbX == e.x && wbMbY == e.y, "R8", "write-back tag",
                160'({wbBeat, wbMbX, wbMbY}), 160'({e.b, e.x, e.y}));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) mLeft[r] = '0;
    repeat (5) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(inReady == 1, "R1", "inReady after reset", 160'(inReady), 160'(1));
    check(winValid == 0 && wbValid == 0 && fltReady == 0, "R1", "nothing pending after reset",
          160'({winValid, wbValid, fltReady}), 160'(0));
    @(posedge clk); #1;
    for (int f = 0; f < FRAMES; f++)
      for (int y = 0; y < FH; y++)
        for (int x = 0; x < FW; x++)
          driveMb(f, x, y);
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (wbQ.size() == 0 && winQ.size() == 0) break;
    end
    @(negedge clk);
    check(winQ.size() == 0, "R3", "all window beats seen", 160'(winQ.size()), 160'(0));
    check(wbQ.size() == 0, "R8", "all write-back beats seen", 160'(wbQ.size()), 160'(0));
    check(inReady == 1, "R10", "idle after two frames", 160'(inReady), 160'(1));
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule